// File: doc/BRIEF.md
# RTC Unlock and Initialization Gate

This block sits in the slow clock domain of a real-time clock and controls who may touch the clock's register file. It watches simple write strobes aimed at two of its own registers. One is an initialization register. Writing a 32-bit key to it puts the timekeeping core through a soft reset of fixed length and then lets it run. The other is an unlock register. Writing a 16-bit password to it opens a write window that closes by itself after a fixed number of clock cycles.

From the unlock state the block decodes a read-permit bit and a write-permit bit for every register of the clock. The surrounding register file uses these bits to drop blocked writes and to return zero on blocked reads. The block also supplies the read-back words of its own two registers. The password never reads back. Only the active bit and the unlock flag are visible.

Top module: `rtc_access_gate`

## Requirements
- R1: A write of the key 0xA5EB1357 to select code 0 raises `core_rst` and clears `active` from the next cycle, for exactly HOLD_CYCLES (default 4) cycles. After that `core_rst` falls and `active` rises. A key write while running starts the same pulse again.
- R2: After power-on reset `core_rst` is 1 and `active` is 0, and they stay so until the key is written. A write of any other value to select code 0 has no effect.
- R3: A write to select code 1 whose low 16 bits equal 0xA965 sets `unlocked` in the next cycle.
- R4: `unlocked` stays 1 for exactly WINDOW (default 512) cycles after the last correct password write, then clears. A correct password written while the flag is set restarts the window, including in the cycle where the flag would have expired.
- R5: A write to select code 1 whose low 16 bits differ from 0xA965 clears `unlocked` in the next cycle.
- R6: Select codes: 0 init, 1 unlock, 2 trim, 3 time load, 4 date load, 5 hour scale, 6 weekday, 7 time alarm, 8 date alarm, 9 leap status, 10 irq enable, 11 irq flags, 12 tick. The bit at index n of `wr_permit` and `rd_permit` belongs to select code n. While `unlocked` is 1, every register may be read and written, except code 9, which is read-only.
- R7: While `unlocked` is 0, codes 3, 4 and 6 may be read but not written, and codes 2, 7, 8 and 12 may be neither read nor written.
- R8: Codes 0, 1, 5, 10 and 11 may always be read and written. Code 9 may always be read and never written.
- R9: `init_rdata` carries `active` in bit 0 and zero elsewhere. `unlk_rdata` carries `unlocked` in bit 16 and zero elsewhere, so the password never reads back.
- R10: A write strobe held low, or a write to any other select code, leaves `unlocked`, `core_rst` and `active` unchanged, whatever the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Register select code of the write |
| wr_data | input | 32 | Write data |
| core_rst | output | 1 | Soft reset to the timekeeping core |
| active | output | 1 | Core is running |
| unlocked | output | 1 | Access window is open |
| wr_permit | output | 13 | Per-register write permit |
| rd_permit | output | 13 | Per-register read permit |
| init_rdata | output | 32 | Read-back word of the init register |
| unlk_rdata | output | 32 | Read-back word of the unlock register |

## Verification
The expiry of the access window and a fresh correct password write can meet in the same cycle. The bench writes the password a second time exactly WINDOW cycles after the first, on the edge where the countdown ends. It then expects `unlocked` to stay 1 and to hold for a full new window. The same collision is met with a wrong password, which must win and clear the flag. A key write that lands during a running soft-reset pulse is judged the same way: the pulse must restart.

// File: rtl/rtc_gate_pkg.sv
package rtc_gate_pkg;

   localparam int NUM_REGS = 13;
   localparam int SEL_W    = 4;

   typedef enum logic [SEL_W-1:0] {
      RG_INIT  = 4'd0,
      RG_UNLK  = 4'd1,
      RG_TRIM  = 4'd2,
      RG_TIME  = 4'd3,
      RG_DATE  = 4'd4,
      RG_SCALE = 4'd5,
      RG_WDAY  = 4'd6,
      RG_TALM  = 4'd7,
      RG_DALM  = 4'd8,
      RG_LEAP  = 4'd9,
      RG_IEN   = 4'd10,
      RG_IFLG  = 4'd11,
      RG_TICK  = 4'd12
   } reg_sel_e;

   // open: always r/w; view: read always, write when unlocked;
   // guard: r/w only when unlocked; status: read always, never write
   typedef enum logic [1:0] {AC_OPEN, AC_VIEW, AC_GUARD, AC_STATUS} acc_class_e;

   typedef enum logic [1:0] {IS_HELD, IS_PULSE, IS_RUN} init_st_e;

   function automatic acc_class_e class_of(input int idx);
      case (idx)
         RG_INIT, RG_UNLK, RG_SCALE, RG_IEN, RG_IFLG: return AC_OPEN;
         RG_TIME, RG_DATE, RG_WDAY:                   return AC_VIEW;
         RG_LEAP:                                     return AC_STATUS;
         default:                                     return AC_GUARD;
      endcase
   endfunction

endpackage

// File: rtl/rtc_init_seq.sv
module rtc_init_seq
   import rtc_gate_pkg::*;
#(
   parameter int              KEY_W       = 32,
   parameter logic [KEY_W-1:0] KEY        = 32'hA5EB1357,
   parameter int              HOLD_CYCLES = 4,
   parameter bit              POR_HELD    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_we,
   input  logic [KEY_W-1:0] init_data,
   output logic             core_rst,
   output logic             active
);

   localparam int HCNT_W = $clog2(HOLD_CYCLES + 1);

   init_st_e           st;
   init_st_e           por_st;
   logic [HCNT_W-1:0]  cnt;
   logic               key_hit;

   generate
      if (POR_HELD) begin : g_por_held
         assign por_st = IS_HELD;
      end else begin : g_por_run
         assign por_st = IS_RUN;
      end
   endgenerate

   assign key_hit = init_we && (init_data == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= por_st;
         cnt <= '0;
      end else if (key_hit) begin
         st  <= IS_PULSE;
         cnt <= HCNT_W'(HOLD_CYCLES - 1);
      end else if (st == IS_PULSE) begin
         if (cnt == '0) st <= IS_RUN;
         else           cnt <= cnt - 1'b1;
      end
   end

   assign core_rst = (st != IS_RUN);
   assign active   = (st == IS_RUN);

endmodule

// File: rtl/rtc_unlock_timer.sv
module rtc_unlock_timer #(
   parameter int               PWD_W  = 16,
   parameter logic [PWD_W-1:0] PWD    = 16'hA965,
   parameter int               WINDOW = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             unlk_we,
   input  logic [PWD_W-1:0] unlk_data,
   output logic             unlocked
);

   localparam int CNT_W = $clog2(WINDOW);

   logic [CNT_W-1:0] left;

   // a password write outranks the countdown in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         left     <= '0;
      end else if (unlk_we) begin
         if (unlk_data == PWD) begin
            unlocked <= 1'b1;
            left     <= CNT_W'(WINDOW - 1);
         end else begin
            unlocked <= 1'b0;
            left     <= '0;
         end
      end else if (unlocked) begin
         if (left == '0) unlocked <= 1'b0;
         else            left     <= left - 1'b1;
      end
   end

endmodule

// File: rtl/rtc_perm_decode.sv
module rtc_perm_decode
   import rtc_gate_pkg::*;
#(
   parameter int NREGS = NUM_REGS
) (
   input  logic             unlocked,
   output logic [NREGS-1:0] wr_permit,
   output logic [NREGS-1:0] rd_permit
);

   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_reg
         localparam acc_class_e CLS = class_of(i);
         if (CLS == AC_OPEN) begin : g_open
            assign wr_permit[i] = 1'b1;
            assign rd_permit[i] = 1'b1;
         end else if (CLS == AC_VIEW) begin : g_view
            assign wr_permit[i] = unlocked;
            assign rd_permit[i] = 1'b1;
         end else if (CLS == AC_STATUS) begin : g_status
            assign wr_permit[i] = 1'b0;
            assign rd_permit[i] = 1'b1;
         end else begin : g_guard
            assign wr_permit[i] = unlocked;
            assign rd_permit[i] = unlocked;
         end
      end
   endgenerate

endmodule

// File: rtl/rtc_access_gate.sv
module rtc_access_gate
   import rtc_gate_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter logic [DATA_W-1:0] KEY         = 32'hA5EB1357,
   parameter int                PWD_W       = 16,
   parameter logic [PWD_W-1:0]  PWD         = 16'hA965,
   parameter int                WINDOW      = 512,
   parameter int                HOLD_CYCLES = 4,
   parameter bit                POR_HELD    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEL_W-1:0]    wr_sel,
   input  logic [DATA_W-1:0]   wr_data,
   output logic                core_rst,
   output logic                active,
   output logic                unlocked,
   output logic [NUM_REGS-1:0] wr_permit,
   output logic [NUM_REGS-1:0] rd_permit,
   output logic [DATA_W-1:0]   init_rdata,
   output logic [DATA_W-1:0]   unlk_rdata
);

   generate
      if (DATA_W <= PWD_W) begin : g_bad_width
         $error("DATA_W must exceed PWD_W to hold the unlock flag");
      end
      if (WINDOW < 2) begin : g_bad_window
         $error("WINDOW must be at least 2");
      end
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 1");
      end
      if ((1 << SEL_W) < NUM_REGS) begin : g_bad_sel
         $error("SEL_W too narrow for NUM_REGS");
      end
   endgenerate

   logic init_we;
   logic unlk_we;

   assign init_we = wr_en && (wr_sel == RG_INIT);
   assign unlk_we = wr_en && (wr_sel == RG_UNLK);

   rtc_init_seq #(
      .KEY_W       (DATA_W),
      .KEY         (KEY),
      .HOLD_CYCLES (HOLD_CYCLES),
      .POR_HELD    (POR_HELD)
   ) u_init (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_we   (init_we),
      .init_data (wr_data),
      .core_rst  (core_rst),
      .active    (active)
   );

   rtc_unlock_timer #(
      .PWD_W  (PWD_W),
      .PWD    (PWD),
      .WINDOW (WINDOW)
   ) u_unlock (
      .clk       (clk),
      .rst_n     (rst_n),
      .unlk_we   (unlk_we),
      .unlk_data (wr_data[PWD_W-1:0]),
      .unlocked  (unlocked)
   );

   rtc_perm_decode #(
      .NREGS (NUM_REGS)
   ) u_perm (
      .unlocked  (unlocked),
      .wr_permit (wr_permit),
      .rd_permit (rd_permit)
   );

   // password field is write-only: only the flag is visible
   always_comb begin
      init_rdata        = '0;
      init_rdata[0]     = active;
      unlk_rdata        = '0;
      unlk_rdata[PWD_W] = unlocked;
   end

endmodule

// File: rtl/rtc_access_gate_chk.sv
module rtc_access_gate_chk
   import rtc_gate_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter logic [DATA_W-1:0] KEY         = 32'hA5EB1357,
   parameter int                PWD_W       = 16,
   parameter logic [PWD_W-1:0]  PWD         = 16'hA965,
   parameter int                WINDOW      = 512,
   parameter int                HOLD_CYCLES = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [SEL_W-1:0]    wr_sel,
   input logic [DATA_W-1:0]   wr_data,
   input logic                core_rst,
   input logic                active,
   input logic                unlocked,
   input logic [NUM_REGS-1:0] wr_permit,
   input logic [NUM_REGS-1:0] rd_permit
);

   localparam int HC_W = $clog2(HOLD_CYCLES + 2) + 1;
   localparam int WC_W = $clog2(WINDOW + 2) + 1;
   localparam logic [NUM_REGS-1:0] GUARD_MASK = 13'h1184;
   localparam logic [NUM_REGS-1:0] OPEN_MASK  = 13'h0C23;

   logic key_wr, pwd_ok, pwd_bad;
   logic [HC_W-1:0] hc;
   logic [WC_W-1:0] wc;

   assign key_wr  = wr_en && (wr_sel == RG_INIT) && (wr_data == KEY);
   assign pwd_ok  = wr_en && (wr_sel == RG_UNLK) && (wr_data[PWD_W-1:0] == PWD);
   assign pwd_bad = wr_en && (wr_sel == RG_UNLK) && (wr_data[PWD_W-1:0] != PWD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                                  hc <= '0;
      else if (key_wr)                                             hc <= HC_W'(1);
      else if (core_rst && hc != '0 && hc <= HC_W'(HOLD_CYCLES))   hc <= hc + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                                  wc <= '0;
      else if (pwd_ok)                                             wc <= WC_W'(1);
      else if (pwd_bad)                                            wc <= '0;
      else if (unlocked && wc != '0 && wc <= WC_W'(WINDOW))        wc <= wc + 1'b1;
   end

   AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr |=> (core_rst && !active)); // R1

   AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst) |-> (hc == HC_W'(HOLD_CYCLES + 1) && active)); // R1

   AST_PWD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      pwd_ok |=> unlocked); // R3

   AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(unlocked) && !$past(pwd_bad)) |-> (wc == WC_W'(WINDOW + 1))); // R4

   AST_PWD_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      pwd_bad |=> !unlocked); // R5

   AST_LEAP_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_permit[RG_LEAP] && !wr_permit[RG_LEAP])); // R6

   AST_LOCKED_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |-> (((wr_permit | rd_permit) & GUARD_MASK) == '0)); // R7

   AST_OPEN_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_permit & rd_permit & OPEN_MASK) == OPEN_MASK)); // R8

endmodule

bind rtc_access_gate rtc_access_gate_chk #(
   .DATA_W      (DATA_W),
   .KEY         (KEY),
   .PWD_W       (PWD_W),
   .PWD         (PWD),
   .WINDOW      (WINDOW),
   .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .core_rst  (core_rst),
   .active    (active),
   .unlocked  (unlocked),
   .wr_permit (wr_permit),
   .rd_permit (rd_permit)
);

// File: tb/rtc_access_gate_test.sv
module rtc_access_gate_test;

   localparam logic [31:0] KEY  = 32'hA5EB1357;
   localparam logic [15:0] PWD  = 16'hA965;
   localparam int          WIN  = 512;
   localparam int          HOLD = 4;
   localparam int          NR   = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_sel = '0;
   logic [31:0]   wr_data = '0;
   logic          core_rst, active, unlocked;
   logic [NR-1:0] wr_permit, rd_permit;
   logic [31:0]   init_rdata, unlk_rdata;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // reference model state
   bit m_run = 1'b0;
   int m_hold = 0;
   int m_left = 0;

   always #2 clk = ~clk;

   rtc_access_gate uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .core_rst(core_rst), .active(active), .unlocked(unlocked),
      .wr_permit(wr_permit), .rd_permit(rd_permit),
      .init_rdata(init_rdata), .unlk_rdata(unlk_rdata)
   );

   // 0 open, 1 view, 2 guard, 3 status
   function automatic int cls(input int i);
      if (i == 0 || i == 1 || i == 5 || i == 10 || i == 11) return 0;
      if (i == 3 || i == 4 || i == 6) return 1;
      if (i == 9) return 3;
      return 2;
   endfunction

   function automatic bit exp_wr(input int i, input bit f);
      case (cls(i))
         0: return 1'b1;
         3: return 1'b0;
         default: return f;
      endcase
   endfunction

   function automatic bit exp_rd(input int i, input bit f);
      return (cls(i) == 2) ? f : 1'b1;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_all();
      bit f;
      f = (m_left > 0);
      chk(m_run ? "R1" : "R2", "core_rst", 32'(core_rst), 32'(!m_run || m_hold > 0));
      chk(m_run ? "R1" : "R2", "active", 32'(active), 32'(m_run && m_hold == 0));
      chk("R4", "unlocked", 32'(unlocked), 32'(f));
      for (int i = 0; i < NR; i++) begin
         string t;
         t = (cls(i) == 0 || cls(i) == 3) ? "R8" : (f ? "R6" : "R7");
         chk(t, $sformatf("wr_permit[%0d]", i), 32'(wr_permit[i]), 32'(exp_wr(i, f)));
         chk(t, $sformatf("rd_permit[%0d]", i), 32'(rd_permit[i]), 32'(exp_rd(i, f)));
      end
      chk("R9", "init_rdata", init_rdata, {31'b0, (m_run && m_hold == 0)});
      chk("R9", "unlk_rdata", unlk_rdata, {15'b0, f, 16'b0});
   endtask

   task automatic step(input logic we, input logic [3:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = we; wr_sel = sel; wr_data = d;
      @(posedge clk);
      if (we && sel == 4'd0 && d == KEY) begin
         m_run = 1'b1; m_hold = HOLD;
      end else if (m_hold > 0) m_hold--;
      if (we && sel == 4'd1) m_left = (d[15:0] == PWD) ? WIN : 0;
      else if (m_left > 0) m_left--;
      #1;
      check_all();
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(1'b0, 4'd0, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL R1 watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed;
      seed = 32'h0000_5EED;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #1;
      // R2: reset state
      chk("R2", "core_rst after POR", 32'(core_rst), 32'd1);
      chk("R2", "active after POR", 32'(active), 32'd0);
      chk("R7", "unlocked after POR", 32'(unlocked), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(3);
      // R2: non-key init write ignored
      step(1'b1, 4'd0, 32'hA5EB1356);
      chk("R2", "core_rst after wrong key", 32'(core_rst), 32'd1);
      idle(2);
      // R1: key write, pulse, release
      step(1'b1, 4'd0, KEY);
      chk("R1", "core_rst after key", 32'(core_rst), 32'd1);
      idle(HOLD - 1);
      chk("R1", "core_rst last pulse cycle", 32'(core_rst), 32'd1);
      idle(1);
      chk("R1", "active after release", 32'(active), 32'd1);
      // R3 / R4: set, run the window, rewrite on the expiry edge
      step(1'b1, 4'd1, {16'h1234, PWD});
      chk("R3", "unlocked after password", 32'(unlocked), 32'd1);
      idle(WIN - 1);
      chk("R4", "unlocked at window end", 32'(unlocked), 32'd1);
      step(1'b1, 4'd1, {16'h0, PWD});
      chk("R4", "unlocked after rewrite on expiry", 32'(unlocked), 32'd1);
      idle(300);
      step(1'b1, 4'd1, {16'hFFFF, PWD});
      idle(WIN - 1);
      chk("R4", "unlocked restarted window", 32'(unlocked), 32'd1);
      idle(1);
      chk("R4", "unlocked expired", 32'(unlocked), 32'd0);
      // R5: wrong password clears at once, also on the expiry edge
      step(1'b1, 4'd1, {16'h0, PWD});
      step(1'b1, 4'd1, {16'h0, 16'hA964});
      chk("R5", "unlocked after bad password", 32'(unlocked), 32'd0);
      step(1'b1, 4'd1, {16'h0, PWD});
      idle(WIN - 1);
      step(1'b1, 4'd1, {16'hA965, 16'h0000});
      chk("R5", "bad password on expiry edge", 32'(unlocked), 32'd0);
      // R10: strobe low or other select leaves state alone
      step(1'b0, 4'd1, {16'h0, PWD});
      chk("R10", "unlocked with strobe low", 32'(unlocked), 32'd0);
      step(1'b1, 4'd3, {16'h0, PWD});
      chk("R10", "unlocked after other select", 32'(unlocked), 32'd0);
      step(1'b0, 4'd0, KEY);
      chk("R10", "active with strobe low key", 32'(active), 32'd1);
      step(1'b1, 4'd1, {16'h0, PWD});
      step(1'b1, 4'd12, 32'h0);
      chk("R10", "unlocked after tick write", 32'(unlocked), 32'd1);
      // R1: key during a running pulse restarts it
      step(1'b1, 4'd0, KEY);
      idle(2);
      step(1'b1, 4'd0, KEY);
      idle(HOLD - 1);
      chk("R1", "restarted pulse still held", 32'(core_rst), 32'd1);
      idle(1);
      chk("R1", "release after restart", 32'(active), 32'd1);
      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = int'($urandom % 100);
         if (r < 4)       step(1'b1, 4'd0, KEY);
         else if (r < 10) step(1'b1, 4'd0, $urandom);
         else if (r < 24) step(1'b1, 4'd1, {$urandom % 65536, PWD} );
         else if (r < 28) step(1'b1, 4'd1, $urandom);
         else if (r < 30) idle(int'($urandom % 600));
         else if (r < 70) step(1'b0, 4'($urandom), $urandom);
         else             step(1'b1, 4'($urandom % 16), $urandom);
      end
      idle(2);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule